// File: doc/BRIEF.md
# Four-Phase Charge Pump Sequencer

This block drives the switch controls of a dual charge pump. The pump builds a positive and a negative rail of equal magnitude from one supply, using two flying capacitors (A and B) and two storage capacitors. The sequencer steps through four phases in a fixed order. Phase 0 charges for the negative rail and phase 1 transfers to it. Phase 2 charges for the positive rail and phase 3 transfers to it. Every phase is timed by dividing the system clock.

Pumping is regulated and runs in bursts. Two comparator inputs report whether the negative rail or the positive rail has fallen below its target magnitude. While either one reports a shortfall, the pump keeps cycling. When neither does, the phase in progress is completed, every switch opens, and the sequencer stays idle. When demand comes back, pumping starts again from phase 0.

Between any two phases there is a dead time with every switch open, so that no two switch states overlap. When the run-enable input is low, the block is in shutdown: every switch opens at once and no phase runs. With `ACTIVE_CYC + DEAD_CYC` clocks per phase, the pump cycles at f_clk / (4 × (ACTIVE_CYC + DEAD_CYC)). The defaults give about 250 kHz from a 250 MHz clock.

Top module: `cp_phase_seq`

## Requirements
- R1: While demand lasts, phases follow the order 0 (negative charge), 1 (negative transfer), 2 (positive charge), 3 (positive transfer), then 0 again. Every pumping burst begins with phase 0.
- R2: In phases 0 and 2 the switch outputs are as follows.
  - `capa_top` = 2'b10: bit1 closes capacitor A's top plate to ground.
  - `capa_bot` = 2'b10: bit1 links capacitor A's bottom plate to capacitor B's bottom plate.
  - `capb_top` = 3'b001: bit0 closes capacitor B's top plate to the supply.
  - `capb_bot` = 2'b00.
- R3: In phase 1 the switch outputs are as follows.
  - `capa_top` = 2'b01: bit0 closes it to the supply.
  - `capa_bot` = 2'b01: bit0 closes it to ground.
  - `capb_top` = 3'b010: bit1 closes it to ground.
  - `capb_bot` = 2'b10: bit1 closes it to the negative storage capacitor.
- R4: In phase 3 the switch outputs are as follows.
  - `capa_top` = 2'b01.
  - `capa_bot` = 2'b01.
  - `capb_top` = 3'b100: bit2 closes it to the positive storage capacitor.
  - `capb_bot` = 2'b01: bit0 closes it to ground.
- R5: Exactly `DEAD_CYC` clocks with every output zero come before each phase. This holds both between consecutive phases and after idle. A non-zero switch pattern never changes directly into another non-zero pattern.
- R6: Each phase holds its pattern for exactly `ACTIVE_CYC` clocks, unless a shutdown cuts it short.
- R7: If no comparator reports a shortfall when a phase ends, the sequencer goes idle with every output zero. When a shortfall is reported again, it resumes from phase 0.
- R8: Each comparator input passes through two synchroniser flops before use. Its value is consulted only while idle and on the last clock of a phase. A change that lasts only within a phase has no effect.
- R9: `run_en` low at a clock edge opens every switch from that edge on and returns the sequencer to idle. The next burst starts with phase 0.
- R10: After synchronous reset every output is zero and the sequencer is idle.
- R11: Demand is the OR of both comparator inputs: either one alone keeps the pump cycling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Low = shutdown, all switches open |
| neg_short | input | 1 | Asynchronous comparator: negative rail magnitude below target |
| pos_short | input | 1 | Asynchronous comparator: positive rail magnitude below target |
| capa_top | output | 2 | Cap A top plate: bit0 supply, bit1 ground |
| capa_bot | output | 2 | Cap A bottom plate: bit0 ground, bit1 link to cap B bottom |
| capb_top | output | 3 | Cap B top plate: bit0 supply, bit1 ground, bit2 positive store |
| capb_bot | output | 2 | Cap B bottom plate: bit0 ground, bit1 negative store |

## Verification
Corrupted internal state shows up at the switch outputs within one phase. A wrong phase index puts a pattern that does not belong into the next drive window. A wrong counter shortens a phase or a dead gap, which is visible as soon as that window closes. A missed stop decision shows as an extra non-zero phase where an idle stretch was due. The bench compares all nine switch lines on every clock with a behavioural model, so any such divergence is reported in the cycle where it first reaches the pins.

// File: rtl/cp_seq_pkg.sv
// Shared types for the charge pump sequencer.
// Assumes: one phase index of two bits; switch groups are one-hot-or-zero.
package cp_seq_pkg;

    typedef enum logic [1:0] {
        PH_NEG_CHG = 2'd0,
        PH_NEG_XFR = 2'd1,
        PH_POS_CHG = 2'd2,
        PH_POS_XFR = 2'd3
    } cp_phase_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GAP   = 2'd1,
        ST_DRIVE = 2'd2
    } cp_state_e;

    // One field per capacitor terminal, each a one-hot-or-zero switch group.
    typedef struct packed {
        logic [1:0] a_top;   // [0] supply, [1] ground
        logic [1:0] a_bot;   // [0] ground, [1] link to B bottom
        logic [2:0] b_top;   // [0] supply, [1] ground, [2] positive store
        logic [1:0] b_bot;   // [0] ground, [1] negative store
    } cp_sw_t;

    localparam cp_sw_t SW_OPEN = '0;

endpackage

// File: rtl/cp_cmp_sync.sv
// Multi-flop synchroniser for the asynchronous rail comparators.
// Assumes: inputs are quasi-static relative to a phase; STAGES >= 1.
module cp_cmp_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] pipe [STAGES];

    // Shift the raw comparator values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d_async;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q_sync = pipe[STAGES-1];

endmodule

// File: rtl/cp_phase_fsm.sv
// Phase sequencer: idle / dead gap / drive, with the four-phase index.
// Assumes: demand is already synchronised; ACTIVE_CYC >= 1, DEAD_CYC >= 1.
// Demand is consulted only while idle and on the last clock of a drive phase.
module cp_phase_fsm
    import cp_seq_pkg::*;
#(
    parameter int ACTIVE_CYC = 230,
    parameter int DEAD_CYC   = 20
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_en,
    input  logic      demand,
    output cp_state_e state_o,
    output cp_phase_e phase_o
);
    localparam int MAXC  = (ACTIVE_CYC > DEAD_CYC) ? ACTIVE_CYC : DEAD_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    cp_state_e        state;
    cp_phase_e        phase;
    logic [CNT_W-1:0] cnt;
    logic             last_clk;

    assign last_clk = (cnt == '0);

    // Advance state, phase index and window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= PH_NEG_CHG;
            cnt   <= '0;
        end else if (!run_en) begin
            state <= ST_IDLE;
            phase <= PH_NEG_CHG;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (demand) begin
                        state <= ST_GAP;
                        phase <= PH_NEG_CHG;
                        cnt   <= CNT_W'(DEAD_CYC - 1);
                    end
                end
                ST_GAP: begin
                    if (last_clk) begin
                        state <= ST_DRIVE;
                        cnt   <= CNT_W'(ACTIVE_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_DRIVE: begin
                    if (last_clk) begin
                        if (demand) begin
                            state <= ST_GAP;
                            phase <= cp_phase_e'(phase + 2'd1);
                            cnt   <= CNT_W'(DEAD_CYC - 1);
                        end else begin
                            state <= ST_IDLE;
                            phase <= PH_NEG_CHG;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    phase <= PH_NEG_CHG;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign state_o = state;
    assign phase_o = phase;

    // R1: a completed phase with demand leads to the next index, wrapping 3 -> 0.
    p_phase_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && state == ST_DRIVE && last_clk && demand)
        |=> (state == ST_GAP && phase == cp_phase_e'($past(phase) + 2'd1)));

    // R7: a completed phase without demand parks idle, ready at phase 0.
    p_stop_parks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRIVE && last_clk && !demand)
        |=> (state == ST_IDLE && phase == PH_NEG_CHG));

    // R8: demand changes inside a drive window do not disturb it.
    p_window_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && state == ST_DRIVE && !last_clk) |=> (state == ST_DRIVE && $stable(phase)));

endmodule

// File: rtl/cp_switch_decode.sv
// Maps sequencer state and phase onto per-terminal switch controls.
// Assumes: outputs are zero outside the drive state (gap, idle, shutdown).
module cp_switch_decode
    import cp_seq_pkg::*;
(
    input  cp_state_e state,
    input  cp_phase_e phase,
    output cp_sw_t    sw
);
    // Select the switch pattern for the current phase.
    always_comb begin
        sw = SW_OPEN;
        if (state == ST_DRIVE) begin
            case (phase)
                PH_NEG_CHG, PH_POS_CHG: begin
                    sw.a_top = 2'b10;
                    sw.a_bot = 2'b10;
                    sw.b_top = 3'b001;
                    sw.b_bot = 2'b00;
                end
                PH_NEG_XFR: begin
                    sw.a_top = 2'b01;
                    sw.a_bot = 2'b01;
                    sw.b_top = 3'b010;
                    sw.b_bot = 2'b10;
                end
                PH_POS_XFR: begin
                    sw.a_top = 2'b01;
                    sw.a_bot = 2'b01;
                    sw.b_top = 3'b100;
                    sw.b_bot = 2'b01;
                end
                default: sw = SW_OPEN;
            endcase
        end
    end

endmodule

// File: rtl/cp_phase_seq.sv
// Top of the four-phase charge pump sequencer.
// Synchronises the rail comparators, runs the phase FSM and decodes switches.
// Assumes: run_en is synchronous to clk; comparator inputs may be asynchronous.
module cp_phase_seq
    import cp_seq_pkg::*;
#(
    parameter int ACTIVE_CYC  = 230,
    parameter int DEAD_CYC    = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       neg_short,
    input  logic       pos_short,
    output logic [1:0] capa_top,
    output logic [1:0] capa_bot,
    output logic [2:0] capb_top,
    output logic [1:0] capb_bot
);
    localparam int MAXC  = (ACTIVE_CYC > DEAD_CYC) ? ACTIVE_CYC : DEAD_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [1:0] short_s;
    logic       demand;
    cp_state_e  state;
    cp_phase_e  phase;
    cp_sw_t     sw;

    cp_cmp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({pos_short, neg_short}),
        .q_sync  (short_s)
    );

    // R11: either rail falling short is enough to pump.
    assign demand = |short_s;

    cp_phase_fsm #(.ACTIVE_CYC(ACTIVE_CYC), .DEAD_CYC(DEAD_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .demand  (demand),
        .state_o (state),
        .phase_o (phase)
    );

    cp_switch_decode u_dec (
        .state (state),
        .phase (phase),
        .sw    (sw)
    );

    assign capa_top = sw.a_top;
    assign capa_bot = sw.a_bot;
    assign capb_top = sw.b_top;
    assign capb_bot = sw.b_bot;

    // ---- observation registers for the port-level checks ----
    logic             any_on, any_on_q, run_en_q;
    cp_sw_t           sw_q;
    logic [CNT_W-1:0] open_run, hold_run;

    assign any_on = (sw != SW_OPEN);

    // Record last cycle's pattern and the run-enable seen at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_on_q <= 1'b0;
            sw_q     <= SW_OPEN;
            run_en_q <= 1'b0;
        end else begin
            any_on_q <= any_on;
            sw_q     <= sw;
            run_en_q <= run_en;
        end
    end

    // Count all-open cycles, saturating at the dead time.
    always_ff @(posedge clk) begin
        if (!rst_n)                      open_run <= '0;
        else if (any_on)                 open_run <= '0;
        else if (open_run != CNT_W'(DEAD_CYC)) open_run <= open_run + 1'b1;
    end

    // Count cycles one non-zero pattern has been held.
    always_ff @(posedge clk) begin
        if (!rst_n)                     hold_run <= '0;
        else if (!any_on)               hold_run <= '0;
        else if (sw == sw_q)            hold_run <= hold_run + 1'b1;
        else                            hold_run <= CNT_W'(1);
    end

    // R2: every terminal closes at most one switch.
    p_onehot_terminals_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(capa_top) && $onehot0(capa_bot) && $onehot0(capb_top) && $onehot0(capb_bot));

    // R5: no direct change from one closed pattern to another.
    p_break_before_make_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_on && any_on_q) |-> (sw == sw_q));

    // R5: a full dead gap precedes every phase.
    p_dead_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_on && !any_on_q) |-> (open_run == CNT_W'(DEAD_CYC)));

    // R6: a phase ended without shutdown lasted exactly ACTIVE_CYC clocks.
    p_phase_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_on && any_on_q && run_en_q) |-> (hold_run == CNT_W'(ACTIVE_CYC)));

    // R9: shutdown at an edge leaves every switch open after it.
    p_shutdown_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en_q |-> !any_on);

endmodule

// File: tb/tb_cp_phase_seq.sv
// Bench: behavioural reference model compared with all switch lines every clock.
module tb_cp_phase_seq;
    localparam int ACT  = 5;
    localparam int DEAD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       neg_short = 1'b0;
    logic       pos_short = 1'b0;
    logic [1:0] capa_top, capa_bot, capb_bot;
    logic [2:0] capb_top;

    always #2 clk = ~clk;

    cp_phase_seq #(.ACTIVE_CYC(ACT), .DEAD_CYC(DEAD), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .neg_short(neg_short), .pos_short(pos_short),
        .capa_top(capa_top), .capa_bot(capa_bot),
        .capb_top(capb_top), .capb_bot(capb_bot)
    );

    int    checks = 0;
    int    errors = 0;
    bit    started = 0;
    bit    done = 0;

    // Reference model: mode 0 idle, 1 gap, 2 drive; left = clocks left in mode.
    int    m_mode = 0, m_phase = 0, m_left = 0;
    string m_tag = "R10";
    bit    qn[$], qp[$];
    bit    dem;

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_mode = 0; m_phase = 0; m_left = 0; m_tag = "R10";
            qn.delete(); qp.delete();
        end else begin
            dem = (qn.size() >= 2) ? (qn[qn.size()-2] | qp[qp.size()-2]) : 1'b0;
            qn.push_back(neg_short);
            qp.push_back(pos_short);
            if (qn.size() > 2) begin
                void'(qn.pop_front());
                void'(qp.pop_front());
            end
            if (!run_en) begin
                m_mode = 0; m_phase = 0; m_tag = "R9";
            end else if (m_mode == 0) begin
                m_tag = "R7/R8/R11";
                if (dem) begin m_mode = 1; m_phase = 0; m_left = DEAD; end
            end else if (m_mode == 1) begin
                m_left--;
                if (m_left == 0) begin m_mode = 2; m_left = ACT; end
            end else begin
                m_left--;
                if (m_left == 0) begin
                    if (dem) begin
                        m_mode = 1; m_phase = (m_phase + 1) % 4; m_left = DEAD;
                    end else begin
                        m_mode = 0; m_phase = 0; m_tag = "R7/R8/R11";
                    end
                end
            end
        end
    end

    function automatic logic [8:0] expect_sw(int mode, int ph);
        if (mode != 2)        return 9'b0;
        if (ph == 0 || ph == 2) return {2'b10, 2'b10, 3'b001, 2'b00};
        if (ph == 1)          return {2'b01, 2'b01, 3'b010, 2'b10};
        return {2'b01, 2'b01, 3'b100, 2'b01};
    endfunction

    function automatic string tag_of(int mode, int ph, string idle_tag);
        if (mode == 1) return "R5";
        if (mode == 0) return idle_tag;
        if (ph == 1)   return "R1/R3/R6";
        if (ph == 3)   return "R1/R4/R6";
        return "R1/R2/R6";
    endfunction

    // Compare every switch line with the model away from the active edge.
    always @(negedge clk) begin
        logic [8:0] got, exp_v;
        if (started && !done) begin
            got   = {capa_top, capa_bot, capb_top, capb_bot};
            exp_v = expect_sw(m_mode, m_phase);
            checks++;
            if (got !== exp_v) begin
                errors++;
                $display("FAIL %s t=%0t switches got %b expected %b",
                         tag_of(m_mode, m_phase, m_tag), $time, got, exp_v);
            end
        end
    end

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R10: reset state
        hold(3);
        rst_n = 1'b1; run_en = 1'b1;
        hold(10);                              // R7 idle with no demand
        neg_short = 1'b1; hold(120);           // R1 R2 R3 R4 R5 R6 full cycles
        neg_short = 1'b0; hold(40);            // R7 finish phase and park
        pos_short = 1'b1; hold(70);            // R11 positive comparator alone
        neg_short = 1'b1; hold(30);
        neg_short = 1'b0;
        for (int k = 0; k < 6; k++) begin      // R8 short drops inside phases
            pos_short = 1'b0; hold(1);
            pos_short = 1'b1; hold(4);
        end
        run_en = 1'b0; hold(12);               // R9 shutdown mid-burst
        run_en = 1'b1; hold(60);               // R9 restart from phase 0
        pos_short = 1'b0; hold(30);
        neg_short = 1'b1; hold(7);             // R7 stop then quick re-arm
        neg_short = 1'b0; hold(3);
        neg_short = 1'b1; hold(50);
        for (int k = 0; k < 4000; k++) begin   // mixed patterns, all tags
            @(negedge clk);
            if ($urandom_range(7) == 0)  neg_short = ~neg_short;
            if ($urandom_range(7) == 0)  pos_short = ~pos_short;
            if ($urandom_range(60) == 0) run_en = ~run_en;
            if (!run_en && $urandom_range(5) == 0) run_en = 1'b1;
        end
        rst_n = 1'b0; hold(2);                 // R10 reset mid-operation
        hold(1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule